// File: doc/BRIEF.md
# Flash Write-Buffer Command Sequencer

This block is the command front end of a flash device for buffered programming. It watches a synchronous write bus that carries the host's address/data command cycles. It recognises a two-cycle unlock prefix followed by a write-to-buffer command at a sector address. After that it takes a word count written as "words minus one", then exactly that many address/data pairs inside one buffer line, and finally a confirm command. Each accepted data word is handed to the array side as a one-cycle load pulse that carries its offset within the line. A confirm starts a programming pulse and a busy period, which here is a counter of fixed length in clock cycles and stands in for the real array.

Any illegal step in a buffered sequence aborts it. The illegal steps are a count above the buffer capacity, a count written to a different sector, a data word outside the selected line, and anything other than the confirm once the last word is in. An abort raises both the program-fail and the write-buffer-abort status bits. The sequencer then ignores every command except a status read and a dedicated three-cycle abort-reset sequence. A one-byte status register can be read through a status-read command and can be cleared with a clear command.

Top module: `wbseq_top`

## Requirements
- R1: After reset the status register reads 80h (bit 7 ready, bits 4 and 3 clear), no load or program pulse is issued, and a read that is not preceded by a status-read command returns 0000h.
- R2: A command starts with the unlock pair: data 00AAh at word address 555h, then data 0055h at word address 2AAh. If the second cycle does not match, or the third cycle is not a known command, the sequencer returns to read mode with no status change, and later buffer-sequence writes are not acted on.
- R3: After the unlock pair, data 0025h at any address (the buffer address) opens a buffered sequence. That address sets the sector (address bits from SECT_LSB upward) and the line (address bits from log2(BUF_DEPTH) upward). The next write must be at the same sector and carries the word count minus one.
- R4: For a count of N−1, exactly N data writes follow. Each one whose address is in the selected line gives one load pulse in the next cycle, with buf_idx equal to the low log2(BUF_DEPTH) address bits and buf_wdata equal to the written data.
- R5: After the last word, data 0029h at any address in the selected sector gives a one-cycle pgm_go pulse with pgm_sector equal to the sector and pgm_cnt_m1 equal to the written count.
- R6: A count value above BUF_DEPTH−1 (255 by default) aborts the sequence at once.
- R7: A data write whose address is outside the selected line aborts the sequence at once and produces no load pulse.
- R8: After the last word, any write other than the confirm aborts the sequence. A count write at a different sector from the buffer address also aborts it.
- R9: An abort sets status bit 4 (program fail) and bit 3 (write-buffer abort) and leaves bit 7 at 1, so the status reads 98h.
- R10: Once aborted, the sequencer acts on no command except a status read and the abort-reset sequence 00AAh@555h, 0055h@2AAh, 00F0h@555h. That sequence returns it to read mode and leaves bits 4 and 3 set.
- R11: Data 0070h at 555h makes the next read return the status byte in bits 7:0 (upper bits 0). The read after that returns 0000h again, and data 00F0h written in read mode cancels a pending status read.
- R12: Data 0071h at 555h in read mode clears status bits 4 and 3.
- R13: After a confirm, status bit 7 reads 0 for BUSY_CYC cycles and then 1. During that time every write except a status read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | A bus write cycle is present this clock |
| wr_addr | input | AW | Word address of the write cycle |
| wr_data | input | DW | Data of the write cycle |
| rd_en | input | 1 | A bus read cycle is present this clock |
| rd_data | output | DW | Read result, registered, updated on each read |
| buf_we | output | 1 | One-cycle pulse: a buffer word was accepted |
| buf_idx | output | log2(BUF_DEPTH) | Offset of the accepted word inside its line |
| buf_wdata | output | DW | Data of the accepted word |
| pgm_go | output | 1 | One-cycle pulse: confirm accepted, programming starts |
| pgm_sector | output | AW−SECT_LSB | Sector being programmed |
| pgm_cnt_m1 | output | log2(BUF_DEPTH) | Number of loaded words minus one |

## Verification
A scoreboard predicts every load pulse and every programming pulse from the address arithmetic alone, and it flags any pulse that was not predicted. The stimulus covers complete sequences at three lengths: a single word, four scattered words, and a full 256-word line. The four-word and full-line cases separate correct offset and count handling from an off-by-one in the minus-one encoding. The stimulus also covers each of the four abort causes on its own, each read back as 98h, so a mutant that drops one cause or sets only one of the two bits shows up. Last, it sends command streams that must be ignored (a broken unlock, commands after an abort, writes while busy) and follows each with writes that would load words if the state had leaked. It then confirms that the abort bits survive the abort reset until the clear command.

// File: rtl/wbseq_pkg.sv
package wbseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_CNT, S_DATA, S_CONF, S_BUSY, S_ABT, S_AUN1, S_AUN2
  } seq_state_t;

  localparam int SR_READY = 7;
  localparam int SR_PFAIL = 4;
  localparam int SR_WBA   = 3;

  localparam logic [15:0] A_UNL1 = 16'h0555;
  localparam logic [15:0] A_UNL2 = 16'h02AA;
  localparam logic [15:0] D_UNL1 = 16'h00AA;
  localparam logic [15:0] D_UNL2 = 16'h0055;
  localparam logic [15:0] D_WBUF = 16'h0025;
  localparam logic [15:0] D_CONF = 16'h0029;
  localparam logic [15:0] D_SRD  = 16'h0070;
  localparam logic [15:0] D_SCLR = 16'h0071;
  localparam logic [15:0] D_RST  = 16'h00F0;

  // address bits at and above lsb, as a plain number
  function automatic logic [31:0] upper_field(input logic [31:0] a, input int lsb);
    return a >> lsb;
  endfunction

  function automatic logic [7:0] pack_status(input logic ready, input logic fail,
                                             input logic wba);
    logic [7:0] s;
    s = 8'h00;
    s[SR_READY] = ready;
    s[SR_PFAIL] = fail;
    s[SR_WBA]   = wba;
    return s;
  endfunction
endpackage

// File: rtl/wbseq_decode.sv
module wbseq_decode
  import wbseq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BUF_DEPTH = 256,
  parameter int SECT_LSB  = 12,
  localparam int LINE_W   = $clog2(BUF_DEPTH)
) (
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] ref_addr,
  output logic          hit_unl1,
  output logic          hit_unl2,
  output logic          hit_wbuf,
  output logic          hit_conf,
  output logic          hit_srd,
  output logic          hit_sclr,
  output logic          hit_rst_any,
  output logic          hit_rst_555,
  output logic          same_sect,
  output logic          same_line,
  output logic          cnt_over
);
  logic at_555, at_2aa;

  always_comb begin
    at_555      = (wr_addr == AW'(A_UNL1));
    at_2aa      = (wr_addr == AW'(A_UNL2));
    same_sect   = upper_field(32'(wr_addr), SECT_LSB) == upper_field(32'(ref_addr), SECT_LSB);
    same_line   = upper_field(32'(wr_addr), LINE_W) == upper_field(32'(ref_addr), LINE_W);
    cnt_over    = 32'(wr_data) > 32'(BUF_DEPTH - 1);
    hit_unl1    = at_555 && (wr_data == DW'(D_UNL1));
    hit_unl2    = at_2aa && (wr_data == DW'(D_UNL2));
    hit_wbuf    = (wr_data == DW'(D_WBUF));
    hit_conf    = same_sect && (wr_data == DW'(D_CONF));
    hit_srd     = at_555 && (wr_data == DW'(D_SRD));
    hit_sclr    = at_555 && (wr_data == DW'(D_SCLR));
    hit_rst_any = (wr_data == DW'(D_RST));
    hit_rst_555 = at_555 && hit_rst_any;
  end
endmodule

// File: rtl/wbseq_timer.sv
module wbseq_timer #(
  parameter int BUSY_CYC = 20,
  localparam int CW      = $clog2(BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= CW'(BUSY_CYC);
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  initial assert (BUSY_CYC >= 1);

  // R13: a confirm leaves the block busy in the following cycle
  a_r13_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R13: the busy period ends only through done
  a_r13_busy_ends_by_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !start) |=> busy);
endmodule

// File: rtl/wbseq_status.sv
module wbseq_status
  import wbseq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort_ev,
  input  logic          clr_ev,
  input  logic          arm_ev,
  input  logic          disarm_ev,
  input  logic          busy,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    sr
);
  logic fail_q, wba_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      wba_q  <= 1'b0;
    end else if (abort_ev) begin
      fail_q <= 1'b1;
      wba_q  <= 1'b1;
    end else if (clr_ev) begin
      fail_q <= 1'b0;
      wba_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    armed_q <= 1'b0;
    else if (arm_ev)               armed_q <= 1'b1;
    else if (rd_en || disarm_ev)   armed_q <= 1'b0;
  end

  always_comb sr = pack_status(!busy, fail_q, wba_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_en)  rd_data <= armed_q ? DW'(sr) : '0;
  end

  // R9: an abort raises both error bits together
  a_r9_abort_bits: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (sr[SR_PFAIL] && sr[SR_WBA]));
  // R12: a clear drops both error bits
  a_r12_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !abort_ev) |=> (!sr[SR_PFAIL] && !sr[SR_WBA]));
  // R9: the two error bits never differ
  a_r9_bits_pair: assert property (@(posedge clk) disable iff (!rst_n)
    sr[SR_PFAIL] == sr[SR_WBA]);
endmodule

// File: rtl/wbseq_fsm.sv
module wbseq_fsm
  import wbseq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BUF_DEPTH = 256,
  parameter int SECT_LSB  = 12,
  localparam int LINE_W   = $clog2(BUF_DEPTH),
  localparam int SECT_W   = AW - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              hit_unl1,
  input  logic              hit_unl2,
  input  logic              hit_wbuf,
  input  logic              hit_conf,
  input  logic              hit_srd,
  input  logic              hit_sclr,
  input  logic              hit_rst_any,
  input  logic              hit_rst_555,
  input  logic              same_sect,
  input  logic              same_line,
  input  logic              cnt_over,
  input  logic              busy_done,
  output logic [AW-1:0]     ref_addr,
  output logic              abort_ev,
  output logic              conf_ev,
  output logic              arm_ev,
  output logic              clr_ev,
  output logic              disarm_ev,
  output logic              buf_we,
  output logic [LINE_W-1:0] buf_idx,
  output logic [DW-1:0]     buf_wdata,
  output logic              pgm_go,
  output logic [SECT_W-1:0] pgm_sector,
  output logic [LINE_W-1:0] pgm_cnt_m1
);
  seq_state_t st, nxt;
  logic [LINE_W-1:0] rem_q;
  logic load_ev, open_ev, count_ev;

  always_comb begin
    nxt       = st;
    abort_ev  = 1'b0;
    conf_ev   = 1'b0;
    arm_ev    = 1'b0;
    clr_ev    = 1'b0;
    disarm_ev = 1'b0;
    load_ev   = 1'b0;
    open_ev   = 1'b0;
    count_ev  = 1'b0;
    if (wr_en) begin
      unique case (st)
        S_IDLE: begin
          if (hit_unl1)         nxt = S_UNL1;
          else if (hit_srd)     arm_ev = 1'b1;
          else if (hit_sclr)    clr_ev = 1'b1;
          else if (hit_rst_any) disarm_ev = 1'b1;
        end
        S_UNL1: nxt = hit_unl2 ? S_UNL2 : S_IDLE;
        S_UNL2: begin
          if (hit_wbuf) begin
            nxt = S_CNT;
            open_ev = 1'b1;
          end else begin
            nxt = S_IDLE;
          end
        end
        S_CNT: begin
          if (!same_sect || cnt_over) begin
            nxt = S_ABT;
            abort_ev = 1'b1;
          end else begin
            nxt = S_DATA;
            count_ev = 1'b1;
          end
        end
        S_DATA: begin
          if (!same_line) begin
            nxt = S_ABT;
            abort_ev = 1'b1;
          end else begin
            load_ev = 1'b1;
            if (rem_q == '0) nxt = S_CONF;
          end
        end
        S_CONF: begin
          if (hit_conf) begin
            nxt = S_BUSY;
            conf_ev = 1'b1;
          end else begin
            nxt = S_ABT;
            abort_ev = 1'b1;
          end
        end
        S_BUSY: if (hit_srd) arm_ev = 1'b1;
        S_ABT: begin
          if (hit_unl1)     nxt = S_AUN1;
          else if (hit_srd) arm_ev = 1'b1;
        end
        S_AUN1: nxt = hit_unl2 ? S_AUN2 : S_ABT;
        S_AUN2: nxt = hit_rst_555 ? S_IDLE : S_ABT;
        default: nxt = S_IDLE;
      endcase
    end
    if (st == S_BUSY && busy_done) nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ref_addr   <= '0;
      rem_q      <= '0;
      buf_we     <= 1'b0;
      buf_idx    <= '0;
      buf_wdata  <= '0;
      pgm_go     <= 1'b0;
      pgm_sector <= '0;
      pgm_cnt_m1 <= '0;
    end else begin
      st     <= nxt;
      buf_we <= load_ev;
      pgm_go <= conf_ev;
      if (open_ev) ref_addr <= wr_addr;
      if (count_ev) begin
        rem_q      <= wr_data[LINE_W-1:0];
        pgm_cnt_m1 <= wr_data[LINE_W-1:0];
      end
      if (load_ev) begin
        rem_q     <= rem_q - LINE_W'(1);
        buf_idx   <= wr_addr[LINE_W-1:0];
        buf_wdata <= wr_data;
      end
      if (conf_ev) pgm_sector <= ref_addr[AW-1:SECT_LSB];
    end
  end

  // R10: the abort state is left only through the unlock prefix of the reset
  a_r10_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ABT && !(wr_en && hit_unl1)) |=> (st == S_ABT));
  // R4: a load pulse always follows a data-phase write
  a_r4_load_from_data: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> ($past(st) == S_DATA));
  // R5: a program pulse always follows the confirm phase
  a_r5_go_from_conf: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_go |-> ($past(st) == S_CONF));
  // R7: a write outside the line never loads
  a_r7_no_load_out_of_line: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && wr_en && !same_line) |=> !buf_we);
  // R5: load and program pulses never coincide
  a_r5_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_we && pgm_go));
endmodule

// File: rtl/wbseq_top.sv
module wbseq_top #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BUF_DEPTH = 256,
  parameter int SECT_LSB  = 12,
  parameter int BUSY_CYC  = 20,
  localparam int LINE_W   = $clog2(BUF_DEPTH),
  localparam int SECT_W   = AW - SECT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  output logic              buf_we,
  output logic [LINE_W-1:0] buf_idx,
  output logic [DW-1:0]     buf_wdata,
  output logic              pgm_go,
  output logic [SECT_W-1:0] pgm_sector,
  output logic [LINE_W-1:0] pgm_cnt_m1
);
  logic [AW-1:0] ref_addr;
  logic hit_unl1, hit_unl2, hit_wbuf, hit_conf, hit_srd, hit_sclr;
  logic hit_rst_any, hit_rst_555, same_sect, same_line, cnt_over;
  logic abort_ev, conf_ev, arm_ev, clr_ev, disarm_ev;
  logic busy, busy_done;
  logic [7:0] sr;

  wbseq_decode #(.AW(AW), .DW(DW), .BUF_DEPTH(BUF_DEPTH), .SECT_LSB(SECT_LSB)) u_dec (
    .wr_addr(wr_addr), .wr_data(wr_data), .ref_addr(ref_addr),
    .hit_unl1(hit_unl1), .hit_unl2(hit_unl2), .hit_wbuf(hit_wbuf), .hit_conf(hit_conf),
    .hit_srd(hit_srd), .hit_sclr(hit_sclr), .hit_rst_any(hit_rst_any),
    .hit_rst_555(hit_rst_555), .same_sect(same_sect), .same_line(same_line),
    .cnt_over(cnt_over)
  );

  wbseq_fsm #(.AW(AW), .DW(DW), .BUF_DEPTH(BUF_DEPTH), .SECT_LSB(SECT_LSB)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hit_unl1(hit_unl1), .hit_unl2(hit_unl2), .hit_wbuf(hit_wbuf), .hit_conf(hit_conf),
    .hit_srd(hit_srd), .hit_sclr(hit_sclr), .hit_rst_any(hit_rst_any),
    .hit_rst_555(hit_rst_555), .same_sect(same_sect), .same_line(same_line),
    .cnt_over(cnt_over), .busy_done(busy_done), .ref_addr(ref_addr),
    .abort_ev(abort_ev), .conf_ev(conf_ev), .arm_ev(arm_ev), .clr_ev(clr_ev),
    .disarm_ev(disarm_ev), .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .pgm_go(pgm_go), .pgm_sector(pgm_sector), .pgm_cnt_m1(pgm_cnt_m1)
  );

  wbseq_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(conf_ev), .busy(busy), .done(busy_done)
  );

  wbseq_status #(.DW(DW)) u_sr (
    .clk(clk), .rst_n(rst_n), .abort_ev(abort_ev), .clr_ev(clr_ev), .arm_ev(arm_ev),
    .disarm_ev(disarm_ev), .busy(busy), .rd_en(rd_en), .rd_data(rd_data), .sr(sr)
  );

  // R13: busy only after a confirm, and never while an abort is flagged in the same cycle
  a_r13_busy_clean: assert property (@(posedge clk) disable iff (!rst_n)
    conf_ev |-> !abort_ev);
  // R1/R13: the ready bit reflects the timer across the boundary
  a_r13_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sr[7]);
endmodule

// File: tb/tb_wbseq_top.sv
module tb_wbseq_top;
  localparam int AW = 16, DW = 16, DEPTH = 256, SLSB = 12, BUSYC = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic buf_we, pgm_go;
  logic [7:0] buf_idx, pgm_cnt_m1;
  logic [DW-1:0] buf_wdata;
  logic [3:0] pgm_sector;

  int tests = 0, fails = 0;
  logic [31:0] exp_load[$];
  logic [31:0] exp_go[$];

  always #10 clk = ~clk;

  wbseq_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_wdata(buf_wdata), .pgm_go(pgm_go), .pgm_sector(pgm_sector),
    .pgm_cnt_m1(pgm_cnt_m1)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares pulses against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && buf_we) begin
      if (exp_load.size() == 0) check(1'b0, "R4 unexpected load", {8'h0, buf_idx, buf_wdata}, 0);
      else begin
        logic [31:0] e;
        e = exp_load.pop_front();
        check({8'h0, buf_idx, buf_wdata} == e, "R4 load", {8'h0, buf_idx, buf_wdata}, e);
      end
    end
    if (rst_n && pgm_go) begin
      if (exp_go.size() == 0) check(1'b0, "R5 unexpected go", {20'h0, pgm_sector, pgm_cnt_m1}, 0);
      else begin
        logic [31:0] e;
        e = exp_go.pop_front();
        check({20'h0, pgm_sector, pgm_cnt_m1} == e, "R5 go", {20'h0, pgm_sector, pgm_cnt_m1}, e);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic status_is(input logic [7:0] exp, input string req);
    logic [15:0] v;
    wr(16'h0555, 16'h0070);
    rd(v);
    check(v == {8'h00, exp}, req, v, {8'h00, exp});
  endtask

  task automatic unlock();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
  endtask

  task automatic open_buf(input logic [15:0] a, input logic [15:0] cnt_m1);
    unlock();
    wr(a, 16'h0025);
    wr((a / 16'h1000) * 16'h1000, cnt_m1);
  endtask

  task automatic load_word(input logic [15:0] a, input logic [15:0] d, input bit expect_ok);
    if (expect_ok) exp_load.push_back({8'h0, a % 16'(DEPTH), d});
    wr(a, d);
  endtask

  task automatic abort_reset();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
    wr(16'h0555, 16'h00F0);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1: reset state
    rd(v);
    check(v == 16'h0000, "R1 plain read after reset", v, 0);
    status_is(8'h80, "R1 reset status");
    // R11: one-shot status read
    rd(v);
    check(v == 16'h0000, "R11 second read not status", v, 0);
    wr(16'h0555, 16'h0070);
    wr(16'h0123, 16'h00F0);
    rd(v);
    check(v == 16'h0000, "R11 F0 cancels status read", v, 0);

    // R3 R4 R5: four scattered words, sector 3, line 31h
    open_buf(16'h3105, 16'h0003);
    load_word(16'h3105, 16'hBEEF, 1);
    load_word(16'h31FF, 16'h1234, 1);
    load_word(16'h3100, 16'h0000, 1);
    load_word(16'h3180, 16'hFFFF, 1);
    exp_go.push_back({20'h0, 4'h3, 8'h03});
    wr(16'h3ABC, 16'h0029);
    // R13: busy right after confirm
    status_is(8'h00, "R13 busy after confirm");
    // R13: writes during busy ignored
    unlock();
    wr(16'h3100, 16'h0025);
    wait_cyc(BUSY_CYC_WAIT());
    wr(16'h3000, 16'h0000);
    wr(16'h3100, 16'h5555);
    status_is(8'h80, "R13 ready and nothing taken during busy");
    check(exp_go.size() == 0 && exp_load.size() == 0, "R5 all pulses seen", exp_go.size(), 0);

    // R2: broken unlock returns to read mode silently
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0056);
    wr(16'h3100, 16'h0025);
    wr(16'h3000, 16'h0000);
    wr(16'h3100, 16'h7777);
    status_is(8'h80, "R2 bad unlock no error");
    unlock();
    wr(16'h3100, 16'h0030);
    wr(16'h3000, 16'h0000);
    wr(16'h3100, 16'h7777);
    status_is(8'h80, "R2 unknown command no error");

    // R4 R5: single word (count 0)
    open_buf(16'h2040, 16'h0000);
    load_word(16'h2041, 16'hA5A5, 1);
    exp_go.push_back({20'h0, 4'h2, 8'h00});
    wr(16'h2000, 16'h0029);
    wait_cyc(BUSYC + 5);
    status_is(8'h80, "R5 single word done");

    // R6: count above capacity
    open_buf(16'h4100, 16'h0100);
    status_is(8'h98, "R6 R9 count overflow aborts");
    // R10: commands ignored while aborted
    open_buf(16'h4100, 16'h0000);
    wr(16'h4100, 16'h1111);
    wr(16'h0555, 16'h0071);
    status_is(8'h98, "R10 sticky abort");
    abort_reset();
    status_is(8'h98, "R10 bits kept after abort reset");
    wr(16'h0555, 16'h0071);
    status_is(8'h80, "R12 clear");

    // R8: count at another sector
    unlock();
    wr(16'h3100, 16'h0025);
    wr(16'h4000, 16'h0000);
    wr(16'h3100, 16'h2222);
    status_is(8'h98, "R8 count sector mismatch");
    abort_reset();
    wr(16'h0555, 16'h0071);

    // R7: word outside the line
    open_buf(16'h6040, 16'h0001);
    load_word(16'h60FF, 16'h0F0F, 1);
    load_word(16'h6100, 16'hF0F0, 0);
    wr(16'h6000, 16'h0029);
    status_is(8'h98, "R7 out of line aborts");
    abort_reset();
    wr(16'h0555, 16'h0071);

    // R8: non-confirm after last word
    open_buf(16'h7000, 16'h0000);
    load_word(16'h7011, 16'h3333, 1);
    wr(16'h7000, 16'h0030);
    status_is(8'h98, "R8 non-confirm aborts");
    abort_reset();
    wr(16'h0555, 16'h0071);
    // R8: confirm in wrong sector
    open_buf(16'h7000, 16'h0000);
    load_word(16'h7022, 16'h4444, 1);
    wr(16'h8000, 16'h0029);
    status_is(8'h98, "R8 confirm wrong sector aborts");
    abort_reset();
    wr(16'h0555, 16'h0071);
    status_is(8'h80, "R12 clear after aborts");

    // R4 R5 R6: full line, count 255 accepted
    open_buf(16'h5200, 16'h00FF);
    for (int i = 0; i < DEPTH; i++) load_word(16'h5200 + 16'(i), 16'(i * 3 + 1), 1);
    exp_go.push_back({20'h0, 4'h5, 8'hFF});
    wr(16'h5ABC, 16'h0029);
    wait_cyc(BUSYC + 5);
    status_is(8'h80, "R6 full line programmed");

    wait_cyc(3);
    check(exp_go.size() == 0 && exp_load.size() == 0, "R4 scoreboard drained",
          exp_load.size() + exp_go.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic int BUSY_CYC_WAIT();
    return BUSYC;
  endfunction
endmodule